// File: doc/BRIEF.md
# Time-Stepped Leaky Integrate-and-Fire Neuron Core

This block evaluates a bank of leaky integrate-and-fire neurons one time step at a time. A single phase controller walks every step through a fixed sequence. It waits in idle and then collects address-event spikes. Each buffered spike then selects one row of a square synapse weight array, and that row is added to every neuron. After that come leak, the threshold test with reset, presentation of the output spike vector, and a handshake with an external learning unit. Once the learning unit reports completion, the controller returns to idle.

The weight array has one row per input axon and one column per neuron. It is filled through a preload port while the core is idle. Membrane potentials are signed and saturate at both ends instead of wrapping. A step that delivers no spikes skips the accumulate phase but still applies leak and the fire test. The full-size core holds 256 neurons. The default parameters give 16 neurons, which keeps the elaborated array small.

Top module: `lif_core`

## Requirements
- R1: After reset `evt_ready`, `out_valid` and `learn_req` are 0 and every membrane potential is 0.
- R2: A `step_go` pulse starts a step only while the core is idle; `evt_ready` is 1 only during spike collection, and a `step_go` at any other time is ignored.
- R3: During collection each cycle with `evt_valid` and `evt_ready` both 1 stores `evt_addr`; the buffer holds `SPK_DEPTH` addresses, and `evt_ready` is 0 once it is full until the step closes; `dl_close` ends collection.
- R4: Every stored spike with axon address a adds weight W[a][j] to neuron j (for all j), in arrival order, duplicates counted each time; `out_spikes` bit j belongs to neuron j.
- R5: Each step, after accumulation, every potential is reduced by `leak_val` (unsigned), also on steps with no spikes.
- R6: A neuron fires only if its potential is strictly greater than the signed `thresh`; a firing neuron's potential becomes 0, equality does not fire.
- R7: `out_valid` is 1 for exactly one cycle per step, carrying the fire result of that step on `out_spikes`.
- R8: `learn_req` rises the cycle after the output pulse and stays 1 until `learn_done` is seen, after which the core is idle; `learn_done` outside that phase has no effect.
- R9: A `wl_en` cycle writes `wl_data` to W[`wl_row`][`wl_col`] only while idle; writes at other times are ignored.
- R10: Potentials are signed 16-bit; accumulation and leak clamp at +32767 and -32768 instead of wrapping.
- R11: With K stored spikes, `out_valid` rises K+3 clock edges after the edge that samples `dl_close` (one address-issue cycle per spike, one drain cycle, leak, fire); with K = 0 it rises 2 edges after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| step_go | input | 1 | Start a time step (idle only) |
| evt_valid | input | 1 | Spike address present |
| evt_addr | input | AW | Axon (row) address of the spike |
| evt_ready | output | 1 | Spike buffer accepts an address |
| dl_close | input | 1 | End of the step's spike list |
| wl_en | input | 1 | Weight preload strobe |
| wl_row | input | AW | Preload axon row |
| wl_col | input | AW | Preload neuron column |
| wl_data | input | WW | Signed weight to store |
| leak_val | input | VW-1 | Unsigned leak subtracted each step |
| thresh | input | VW | Signed firing threshold |
| out_valid | output | 1 | Output spike vector valid |
| out_spikes | output | N | Fire result, bit j for neuron j |
| learn_req | output | 1 | Request to the learning unit |
| learn_done | input | 1 | Learning unit finished |

## Verification
The bench sweeps spike counts from zero up to one past the buffer size, with duplicated addresses and rotating leak and threshold values. Each output vector is compared with an arithmetic model. On some steps the threshold is set to a neuron's exact pre-fire potential, so a design that fires on equality shows a set bit where a clear one is expected. Long runs of maximum and minimum weights drive potentials into both rails: a wrapping adder would turn a near-full neuron negative and never fire it, and a wrapping leak would flip a floor-pinned neuron positive. Weight writes and start pulses are also issued during the learning wait, so a core that honoured them would later show altered spikes or an unexpected `evt_ready`. The latency to `out_valid` is counted for zero and non-zero spike counts, which exposes a core that runs an empty accumulate phase or drops the drain cycle.

// File: rtl/lif_pkg.sv
package lif_pkg;

  // Per-time-step phases, in the order the controller visits them.
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_DNLD  = 3'd1,
    PH_GEN   = 3'd2,
    PH_LEAK  = 3'd3,
    PH_FIRE  = 3'd4,
    PH_UPLD  = 3'd5,
    PH_LEARN = 3'd6
  } phase_t;

endpackage

// File: rtl/lif_seq.sv
module lif_seq
  import lif_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   step_go,
  input  logic   dl_close,
  input  logic   has_spk,
  input  logic   gen_last,
  input  logic   learn_done,
  output phase_t phase
);

  phase_t ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE:  if (step_go)    ph_d = PH_DNLD;
      PH_DNLD:  if (dl_close)   ph_d = has_spk ? PH_GEN : PH_LEAK;
      PH_GEN:   if (gen_last)   ph_d = PH_LEAK;
      PH_LEAK:                  ph_d = PH_FIRE;
      PH_FIRE:                  ph_d = PH_UPLD;
      PH_UPLD:                  ph_d = PH_LEARN;
      PH_LEARN: if (learn_done) ph_d = PH_IDLE;
      default:                  ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  assign phase = ph_q;

endmodule

// File: rtl/lif_spike_buf.sv
module lif_spike_buf #(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [IW-1:0] rd_ptr,
  output logic [AW-1:0] rd_addr,
  output logic [CW-1:0] cnt,
  output logic          full
);

  logic [AW-1:0] slot [DEPTH];
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (push) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr | push) cnt_q <= cnt_d;
  end

  // Storage needs no reset: entries are only read below the count.
  always_ff @(posedge clk) begin
    if (push) slot[cnt_q[IW-1:0]] <= push_addr;
  end

  assign rd_addr = slot[rd_ptr];
  assign cnt     = cnt_q;
  assign full    = (cnt_q == CW'(DEPTH));

endmodule

// File: rtl/lif_syn_mem.sv
module lif_syn_mem #(
  parameter int N  = 16,
  parameter int WW = 8,
  localparam int AW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_row,
  input  logic [AW-1:0]   wr_col,
  input  logic [WW-1:0]   wr_data,
  input  logic            rd_en,
  input  logic [AW-1:0]   rd_row,
  output logic [N*WW-1:0] rd_data,
  output logic            rd_vld
);

  // One row per axon, one WW-bit field per neuron column.
  logic [N*WW-1:0] mem [N];
  logic [N*WW-1:0] rd_q;
  logic            vld_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_row][int'(wr_col)*WW +: WW] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= mem[rd_row];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= rd_en;
  end

  assign rd_data = rd_q;
  assign rd_vld  = vld_q;

endmodule

// File: rtl/lif_neuron_bank.sv
module lif_neuron_bank #(
  parameter int N  = 16,
  parameter int WW = 8,
  parameter int VW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc_en,
  input  logic [N*WW-1:0]      acc_row,
  input  logic                 leak_en,
  input  logic [VW-2:0]        leak_val,
  input  logic                 fire_en,
  input  logic signed [VW-1:0] thresh,
  output logic [N-1:0]         spikes
);

  localparam logic signed [VW-1:0] VMAX = {1'b0, {(VW-1){1'b1}}};
  localparam logic signed [VW-1:0] VMIN = {1'b1, {(VW-1){1'b0}}};

  logic upd_en;
  assign upd_en = acc_en | leak_en | fire_en;

  for (genvar j = 0; j < N; j++) begin : g_nrn
    logic signed [VW-1:0] v_q, v_d;
    logic                 s_q, s_d;
    logic        [WW-1:0] w;
    logic signed [VW:0]   sum, dif;

    assign w = acc_row[j*WW +: WW];

    always_comb begin
      sum = {v_q[VW-1], v_q} + {{(VW+1-WW){w[WW-1]}}, w};
      dif = {v_q[VW-1], v_q} - {2'b00, leak_val};
      v_d = v_q;
      s_d = s_q;
      if (acc_en) begin
        if (sum[VW] != sum[VW-1]) v_d = sum[VW] ? VMIN : VMAX;
        else                      v_d = sum[VW-1:0];
      end else if (leak_en) begin
        if (dif[VW] != dif[VW-1]) v_d = dif[VW] ? VMIN : VMAX;
        else                      v_d = dif[VW-1:0];
      end else if (fire_en) begin
        s_d = (v_q > thresh);
        if (s_d) v_d = '0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= '0;
        s_q <= 1'b0;
      end else if (upd_en) begin
        v_q <= v_d;
        s_q <= s_d;
      end
    end

    assign spikes[j] = s_q;
  end

endmodule

// File: rtl/lif_core.sv
module lif_core
  import lif_pkg::*;
#(
  parameter int N         = 16,
  parameter int WW        = 8,
  parameter int VW        = 16,
  parameter int SPK_DEPTH = 16,
  localparam int AW       = $clog2(N),
  localparam int IW       = $clog2(SPK_DEPTH),
  localparam int CW       = $clog2(SPK_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_go,
  input  logic          evt_valid,
  input  logic [AW-1:0] evt_addr,
  output logic          evt_ready,
  input  logic          dl_close,
  input  logic          wl_en,
  input  logic [AW-1:0] wl_row,
  input  logic [AW-1:0] wl_col,
  input  logic [WW-1:0] wl_data,
  input  logic [VW-2:0] leak_val,
  input  logic [VW-1:0] thresh,
  output logic          out_valid,
  output logic [N-1:0]  out_spikes,
  input  logic          learn_done,
  output logic          learn_req
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sync_n = rst_q[1];

  phase_t          phase;
  logic            push, buf_full, has_spk;
  logic [CW-1:0]   buf_cnt;
  logic [AW-1:0]   rd_axon;
  logic [CW-1:0]   rd_idx_q, rd_idx_d;
  logic            in_gen, issue, gen_last;
  logic [N*WW-1:0] row_data;
  logic            row_vld;

  assign evt_ready = (phase == PH_DNLD) && !buf_full;
  assign push      = evt_valid && evt_ready;
  assign has_spk   = (buf_cnt != '0) || push;

  assign in_gen    = (phase == PH_GEN);
  assign issue     = in_gen && (rd_idx_q != buf_cnt);
  assign gen_last  = in_gen && (rd_idx_q == buf_cnt);

  lif_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .step_go    (step_go),
    .dl_close   (dl_close),
    .has_spk    (has_spk),
    .gen_last   (gen_last),
    .learn_done (learn_done),
    .phase      (phase)
  );

  lif_spike_buf #(.DEPTH(SPK_DEPTH), .AW(AW)) u_buf (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .clr       ((phase == PH_IDLE) && step_go),
    .push      (push),
    .push_addr (evt_addr),
    .rd_ptr    (rd_idx_q[IW-1:0]),
    .rd_addr   (rd_axon),
    .cnt       (buf_cnt),
    .full      (buf_full)
  );

  // Read index walks the buffer during the accumulate phase.
  always_comb begin
    rd_idx_d = rd_idx_q;
    if (!in_gen)    rd_idx_d = '0;
    else if (issue) rd_idx_d = rd_idx_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                rd_idx_q <= '0;
    else if (issue || !in_gen) rd_idx_q <= rd_idx_d;
  end

  lif_syn_mem #(.N(N), .WW(WW)) u_syn (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wl_en && (phase == PH_IDLE)),
    .wr_row  (wl_row),
    .wr_col  (wl_col),
    .wr_data (wl_data),
    .rd_en   (issue),
    .rd_row  (rd_axon),
    .rd_data (row_data),
    .rd_vld  (row_vld)
  );

  lif_neuron_bank #(.N(N), .WW(WW), .VW(VW)) u_bank (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .acc_en   (row_vld),
    .acc_row  (row_data),
    .leak_en  (phase == PH_LEAK),
    .leak_val (leak_val),
    .fire_en  (phase == PH_FIRE),
    .thresh   (thresh),
    .spikes   (out_spikes)
  );

  assign out_valid = (phase == PH_UPLD);
  assign learn_req = (phase == PH_LEARN);

endmodule

// File: rtl/lif_core_chk.sv
module lif_core_chk
  import lif_pkg::*;
#(
  parameter int SPK_DEPTH = 16,
  parameter int CW        = 5
) (
  input logic          clk,
  input logic          rst_sync_n,
  input phase_t        phase,
  input logic          evt_valid,
  input logic          evt_ready,
  input logic          dl_close,
  input logic [CW-1:0] buf_cnt,
  input logic          out_valid,
  input logic          learn_req,
  input logic          learn_done
);

  // R7
  out_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid |=> !out_valid);

  // R7
  upld_after_fire_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid |-> $past(phase == PH_FIRE));

  // R8
  learn_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (learn_req && !learn_done) |=> learn_req);

  // R8
  learn_exit_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (learn_req && learn_done) |=> (phase == PH_IDLE));

  // R2
  dl_entry_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(evt_ready) |-> $past(phase == PH_IDLE));

  // R3
  push_count_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (evt_valid && evt_ready && !dl_close) |=> (buf_cnt == $past(buf_cnt) + CW'(1)));

  // R3
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (buf_cnt == CW'(SPK_DEPTH)) |-> !evt_ready);

  // R11
  empty_skip_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (phase == PH_DNLD && dl_close && buf_cnt == '0 && !evt_valid) |=> (phase == PH_LEAK));

endmodule

bind lif_core lif_core_chk #(.SPK_DEPTH(SPK_DEPTH), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .phase      (phase),
  .evt_valid  (evt_valid),
  .evt_ready  (evt_ready),
  .dl_close   (dl_close),
  .buf_cnt    (buf_cnt),
  .out_valid  (out_valid),
  .learn_req  (learn_req),
  .learn_done (learn_done)
);

// File: tb/lif_core_bench.sv
module lif_core_bench;

  localparam int N  = 16;
  localparam int WW = 8;
  localparam int VW = 16;
  localparam int SD = 16;

  logic          clk, rst_n;
  logic          step_go, evt_valid, evt_ready, dl_close;
  logic [3:0]    evt_addr;
  logic          wl_en;
  logic [3:0]    wl_row, wl_col;
  logic [WW-1:0] wl_data;
  logic [VW-2:0] leak_val;
  logic [VW-1:0] thresh;
  logic          out_valid, learn_done, learn_req;
  logic [N-1:0]  out_spikes;

  lif_core #(.N(N), .WW(WW), .VW(VW), .SPK_DEPTH(SD)) u_lif_core (
    .clk(clk), .rst_n(rst_n), .step_go(step_go), .evt_valid(evt_valid),
    .evt_addr(evt_addr), .evt_ready(evt_ready), .dl_close(dl_close),
    .wl_en(wl_en), .wl_row(wl_row), .wl_col(wl_col), .wl_data(wl_data),
    .leak_val(leak_val), .thresh(thresh), .out_valid(out_valid),
    .out_spikes(out_spikes), .learn_done(learn_done), .learn_req(learn_req)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int W [N][N];
  int V [N];
  int spk [32];
  int lfsr = 32'h1ace;

  function automatic int sat(input int x);
    if (x > 32767)  return 32767;
    if (x < -32768) return -32768;
    return x;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_w(input int r, input int c, input int val);
    wl_en = 1'b1; wl_row = 4'(r); wl_col = 4'(c); wl_data = WW'(val);
    tick();
    wl_en = 1'b0;
    W[r][c] = val;
  endtask

  function automatic int next_rand();
    lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hb400 : 0);
    return lfsr;
  endfunction

  // n spikes from spk[]; eq_n >= 0 puts the threshold on that neuron's potential.
  task automatic run_step(input int n, input int lk, input int thr_in, input int eq_n,
                          input string tag);
    int vp [N];
    int k, m, thr, exp_lat;
    logic [N-1:0] exp_s;
    k = (n > SD) ? SD : n;
    for (int j = 0; j < N; j++) begin
      vp[j] = V[j];
      for (int i = 0; i < k; i++) vp[j] = sat(vp[j] + W[spk[i]][j]);
      vp[j] = sat(vp[j] - lk);
    end
    thr = (eq_n >= 0) ? vp[eq_n] : thr_in;
    for (int j = 0; j < N; j++) begin
      exp_s[j] = (vp[j] > thr);
      V[j] = exp_s[j] ? 0 : vp[j];
    end
    leak_val = (VW-1)'(lk);
    thresh   = VW'(thr);
    step_go  = 1'b1;
    tick();
    step_go  = 1'b0;
    for (int i = 0; i < n; i++) begin
      evt_valid = 1'b1;
      evt_addr  = 4'(spk[i]);
      #1;
      // R3: ready while buffer has room
      chk(evt_ready == (i < SD), "R3 evt_ready", int'(evt_ready), int'(i < SD));
      tick();
    end
    evt_valid = 1'b0;
    dl_close  = 1'b1;
    tick();
    dl_close  = 1'b0;
    m = 1;
    while (!out_valid && m < 60) begin
      tick();
      m++;
    end
    exp_lat = (k > 0) ? k + 4 : 3;
    // R11: latency from close to output pulse
    chk(m == exp_lat, "R11 latency", m, exp_lat);
    // R4 R5 R6 R10: spike vector against the arithmetic model
    chk(out_spikes == exp_s, {"R4 R5 R6 R10 spikes ", tag}, int'(out_spikes), int'(exp_s));
    if (eq_n >= 0)
      chk(out_spikes[eq_n] == 1'b0, "R6 equality no fire", int'(out_spikes[eq_n]), 0);
    tick();
    // R7: one-cycle pulse; R8: request follows
    chk(out_valid == 1'b0, "R7 pulse width", int'(out_valid), 0);
    chk(learn_req == 1'b1, "R8 learn_req", int'(learn_req), 1);
    // R9: write during learning must be ignored (model left unchanged)
    wl_en = 1'b1; wl_row = 4'(n % N); wl_col = 4'((n * 3) % N);
    wl_data = WW'(W[n % N][(n * 3) % N] + 55);
    step_go = 1'b1;
    tick();
    wl_en = 1'b0;
    chk(learn_req == 1'b1, "R8 learn_req held", int'(learn_req), 1);
    learn_done = 1'b1;
    tick();
    learn_done = 1'b0;
    step_go = 1'b0;
    chk(learn_req == 1'b0, "R8 learn exit", int'(learn_req), 0);
    // R2: start pulse during learning did not open a step
    chk(evt_ready == 1'b0, "R2 ignored start", int'(evt_ready), 0);
    // R8: stray done while idle has no effect
    learn_done = 1'b1;
    tick();
    learn_done = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; step_go = 0; evt_valid = 0; evt_addr = 0; dl_close = 0;
    wl_en = 0; wl_row = 0; wl_col = 0; wl_data = 0; leak_val = 0; thresh = 0;
    learn_done = 0;
    for (int j = 0; j < N; j++) V[j] = 0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    chk(evt_ready == 1'b0, "R1 evt_ready", int'(evt_ready), 0);
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(learn_req == 1'b0, "R1 learn_req", int'(learn_req), 0);
    rst_n = 1'b1;
    repeat (4) tick();

    for (int a = 0; a < N; a++)
      for (int j = 0; j < N; j++)
        write_w(a, j, ((a * 7 + j * 13 + 5) % 61) - 30);

    // R1: potentials start at zero (equal to 0 does not fire, above -1 does)
    run_step(0, 0, 0, -1, "R1 zero thr");
    run_step(0, 0, -1, -1, "R1 neg thr");

    for (int s = 0; s < 48; s++) begin
      int n;
      n = s % 18;
      for (int i = 0; i < n; i++) spk[i] = next_rand() % N;
      if (n > 2) spk[1] = spk[0];
      run_step(n, (s * 37) % 200, ((s * 53) % 400) - 100, (s % 3 == 0) ? s % N : -1, "sweep");
    end

    // R10: drive potentials into the upper rail
    for (int j = 0; j < N; j++) write_w(0, j, 127);
    for (int j = 0; j < N; j++) write_w(1, j, -128);
    for (int i = 0; i < 32; i++) spk[i] = 0;
    for (int s = 0; s < 20; s++) run_step(16, 0, 32766, -1, "R10 top rail");
    // R10: drive into the lower rail, then leak hard against it
    for (int i = 0; i < 32; i++) spk[i] = 1;
    for (int s = 0; s < 20; s++) run_step(16, 0, 32767, -1, "R10 bottom rail");
    run_step(0, 32767, 32767, -1, "R10 leak floor");
    spk[0] = 0;
    run_step(1, 0, 0, 0, "R10 off floor");
    run_step(0, 0, -32768, -1, "R10 final");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    fails++;
    $display("FAIL R11 watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule